// File: doc/BRIEF.md
# Gated One-Shot Pulse Timer

This block turns a qualified edge on one of three control inputs into a single output pulse of programmable length, counted in clock cycles. Two of the inputs are trigger inputs of opposite sense: a falling-edge trigger and a rising-edge trigger. The third is an active-low clear. Each input can start a pulse only when the other two are at the right levels, so each can also serve as an enable for the others. The pulse length is taken from a width input when the trigger is accepted.

All inputs are sampled on the clock. An edge is found by comparing the current sample with the sample from the previous clock. The timer cannot be retriggered while it runs. A trigger on the last cycle of a pulse is still accepted, so pulses can follow one another with no gap. The clear input ends a running pulse and blocks every trigger for as long as it is low.

Top module: `gated_oneshot`

## Requirements
- R1: After reset, and whenever no pulse is running, `q` is 0 and `q_n` is 1.
- R2: A 1-to-0 change on `trig_fall_n` starts a pulse only if, in the same cycle, `trig_rise` is 1 and `clr_n` is 1.
- R3: A 0-to-1 change on `trig_rise` starts a pulse only if, in the same cycle, `trig_fall_n` is 0 and `clr_n` is 1.
- R4: A 0-to-1 change on `clr_n` starts a pulse when `trig_fall_n` is 0 and `trig_rise` is 1. With `trig_fall_n` at 1 it starts nothing.
- R5: A trigger seen at clock edge n makes `q` 1 from edge n onward for exactly W cycles. W is the value of `width` at edge n, and changes to `width` during the pulse have no effect.
- R6: A captured `width` of 0 gives a pulse of one cycle.
- R7: Qualified triggers that arrive while a pulse is running, other than on its last cycle, are ignored and do not lengthen the pulse.
- R8: A qualified trigger on the last cycle of a pulse is accepted. The new pulse follows at once, with `q` staying 1.
- R9: `clr_n` sampled at 0 forces `q` to 0 at that edge, even if the pulse has not run its full width.
- R10: While `clr_n` is 0, edges on `trig_fall_n` and `trig_rise` start nothing and `q` stays 0.
- R11: `q_n` is always the complement of `q`.
- R12: Synchronous active-high `rst` returns the block to rest at the next edge. The input history is loaded from the current inputs, so no edge is seen across reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_n | input | 1 | Trigger on a falling edge |
| trig_rise | input | 1 | Trigger on a rising edge |
| clr_n | input | 1 | Clear, active low; its rising edge can also trigger |
| width | input | WW | Pulse length in cycles, captured when a trigger is accepted |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions assume that every input is synchronous to the clock and is sampled once per edge. They also assume that reset is asserted from time zero, so the input history and the counter start from defined values. The bench meets these assumptions by changing inputs only on the falling clock edge and by holding reset for several cycles at fixed input levels. It then walks the gating combinations, back-to-back triggers, clear cuts and a long width. It also applies reset in the middle of a pulse, with input levels that would look like a trigger if the history were not reloaded.

// File: rtl/gated_oneshot_pkg.sv
package gated_oneshot_pkg;
   // Bit positions of the three control inputs inside the sampled vector.
   localparam int unsigned IN_COUNT = 3;
   localparam int unsigned IDX_FALL = 0;
   localparam int unsigned IDX_RISE = 1;
   localparam int unsigned IDX_CLR  = 2;
   // Edge polarity per input bit: 1 = detect 0->1, 0 = detect 1->0.
   localparam logic [IN_COUNT-1:0] EDGE_POLARITY = 3'b110;
endpackage

// File: rtl/edge_tracker.sv
module edge_tracker #(
   parameter int unsigned          N   = 3,
   parameter logic [N-1:0]         POL = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] din,
   output logic [N-1:0] evt
);
   logic [N-1:0] hist_q;

   // Reset loads the history from the live inputs, so no edge is seen across release.
   always_ff @(posedge clk) begin
      hist_q <= din;
      if (rst) hist_q <= din;
   end

   for (genvar i = 0; i < N; i++) begin : g_edge
      if (POL[i]) begin : g_rise
         assign evt[i] = ~rst & din[i] & ~hist_q[i];
      end else begin : g_fall
         assign evt[i] = ~rst & ~din[i] & hist_q[i];
      end
   end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
   parameter int unsigned WW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr_lvl,
   input  logic          fire,
   input  logic [WW-1:0] width,
   output logic          pulse
);
   localparam logic [WW-1:0] ONE = WW'(1);

   logic          busy_q;
   logic [WW-1:0] rem_q;
   logic          last_cyc;
   logic          accept;

   assign last_cyc = busy_q && (rem_q == '0);
   assign accept   = fire && (!busy_q || last_cyc);

   always_ff @(posedge clk) begin
      if (rst || !clr_lvl) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         rem_q  <= (width == '0) ? '0 : width - ONE;
      end else if (busy_q) begin
         if (rem_q == '0) busy_q <= 1'b0;
         else             rem_q  <= rem_q - ONE;
      end
   end

   assign pulse = busy_q;

   // R9
   clr_cut_chk: assert property (@(posedge clk) disable iff (rst)
      !clr_lvl |=> !pulse);

   // R7
   no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && rem_q != '0 && clr_lvl) |=> (busy_q && rem_q == $past(rem_q) - ONE));

   // R6
   zero_width_chk: assert property (@(posedge clk) disable iff (rst)
      (fire && !busy_q && width == '0) |=> (busy_q && rem_q == '0));

   // R8
   back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      (last_cyc && fire) |=> pulse);
endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
   import gated_oneshot_pkg::*;
#(
   parameter int unsigned WW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          trig_fall_n,
   input  logic          trig_rise,
   input  logic          clr_n,
   input  logic [WW-1:0] width,
   output logic          q,
   output logic          q_n
);
   if (WW < 1 || WW > 32) begin : g_bad_ww
      $error("gated_oneshot: WW must lie in 1..32");
   end

   logic [IN_COUNT-1:0] lvl;
   logic [IN_COUNT-1:0] evt;
   logic                fire;
   logic                pulse;

   assign lvl[IDX_FALL] = trig_fall_n;
   assign lvl[IDX_RISE] = trig_rise;
   assign lvl[IDX_CLR]  = clr_n;

   edge_tracker #(.N(IN_COUNT), .POL(EDGE_POLARITY)) u_edges (
      .clk (clk),
      .rst (rst),
      .din (lvl),
      .evt (evt)
   );

   // Each input qualifies only with the other two at their enabling levels.
   assign fire = clr_n & ( (evt[IDX_FALL] &  trig_rise)
                         | (evt[IDX_RISE] & ~trig_fall_n)
                         | (evt[IDX_CLR]  & ~trig_fall_n & trig_rise));

   pulse_timer #(.WW(WW)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .clr_lvl (clr_n),
      .fire    (fire),
      .width   (width),
      .pulse   (pulse)
   );

   assign q   = pulse;
   assign q_n = ~pulse;

   // R5
   rise_needs_fire_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(q) |-> $past(fire));

   // R10
   clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      !clr_n |-> !fire);
endmodule

// File: tb/sim_gated_oneshot.sv
module sim_gated_oneshot;
   localparam int unsigned WW = 8;
   localparam int unsigned NV = 36;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic a = 1'b1, b = 1'b1, c = 1'b1;
   logic [WW-1:0] w = '0;
   logic q, q_n;
   int   total = 0, failed = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   gated_oneshot #(.WW(WW)) u0 (
      .clk(clk), .rst(rst), .trig_fall_n(a), .trig_rise(b), .clr_n(c),
      .width(w), .q(q), .q_n(q_n)
   );

   // Fields: [11:8] requirement, [7] trig_fall_n, [6] trig_rise, [5] clr_n,
   // [4:1] width, [0] expected q after the edge that samples this row.
   localparam logic [11:0] VEC [NV] = '{
      {4'd1,  3'b111, 4'd3, 1'b0},  // R1 idle
      {4'd2,  3'b011, 4'd3, 1'b1},  // R2 falling trigger
      {4'd5,  3'b011, 4'd3, 1'b1},
      {4'd5,  3'b111, 4'd3, 1'b1},
      {4'd5,  3'b111, 4'd3, 1'b0},  // R5 ends after 3
      {4'd2,  3'b101, 4'd3, 1'b0},
      {4'd2,  3'b001, 4'd3, 1'b0},  // R2 blocked by trig_rise low
      {4'd3,  3'b011, 4'd2, 1'b1},  // R3 rising trigger
      {4'd5,  3'b001, 4'd2, 1'b1},
      {4'd8,  3'b011, 4'd2, 1'b1},  // R8 trigger on last cycle
      {4'd8,  3'b011, 4'd2, 1'b1},
      {4'd8,  3'b001, 4'd2, 1'b0},
      {4'd3,  3'b011, 4'd4, 1'b1},
      {4'd7,  3'b001, 4'd4, 1'b1},
      {4'd7,  3'b011, 4'd4, 1'b1},  // R7 ignored mid-pulse
      {4'd7,  3'b011, 4'd4, 1'b1},
      {4'd7,  3'b011, 4'd4, 1'b0},  // R7 not stretched
      {4'd10, 3'b010, 4'd4, 1'b0},
      {4'd4,  3'b011, 4'd1, 1'b1},  // R4 clear rising triggers
      {4'd4,  3'b011, 4'd1, 1'b0},
      {4'd4,  3'b111, 4'd5, 1'b0},
      {4'd2,  3'b011, 4'd5, 1'b1},
      {4'd5,  3'b011, 4'd5, 1'b1},
      {4'd9,  3'b010, 4'd5, 1'b0},  // R9 cut short
      {4'd9,  3'b110, 4'd5, 1'b0},
      {4'd10, 3'b010, 4'd5, 1'b0},  // R10 fall blocked
      {4'd10, 3'b000, 4'd5, 1'b0},
      {4'd10, 3'b010, 4'd5, 1'b0},  // R10 rise blocked
      {4'd10, 3'b110, 4'd5, 1'b0},
      {4'd4,  3'b111, 4'd5, 1'b0},  // R4 clear rising with fall input high
      {4'd6,  3'b011, 4'd0, 1'b1},  // R6 zero width
      {4'd6,  3'b011, 4'd0, 1'b0},
      {4'd5,  3'b111, 4'd2, 1'b0},
      {4'd5,  3'b011, 4'd2, 1'b1},
      {4'd5,  3'b011, 4'd7, 1'b1},  // R5 width change ignored
      {4'd5,  3'b011, 4'd7, 1'b0}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", q, 1'b0);
      chk("R1", q_n, 1'b1);
      @(negedge clk) rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         a = VEC[k][7];
         b = VEC[k][6];
         c = VEC[k][5];
         w = WW'(VEC[k][4:1]);
         step();
         chk($sformatf("R%0d row %0d", VEC[k][11:8], k), q, VEC[k][0]);
         chk("R11", q_n, ~q);
      end

      // R5 long pulse counted cycle by cycle
      begin
         int hi = 0;
         @(negedge clk) begin a = 1'b1; w = WW'(200); end
         step();
         @(negedge clk) a = 1'b0;
         for (int i = 0; i < 260; i++) begin
            step();
            if (q) hi++;
         end
         chk("R5 long width", (hi == 200), 1'b1);
         if (hi != 200) $display("  long pulse length %0d, expected 200", hi);
      end

      // R12 reset in the middle of a pulse
      @(negedge clk) begin a = 1'b1; w = WW'(50); end
      step();
      @(negedge clk) a = 1'b0;
      step();
      chk("R5", q, 1'b1);
      repeat (5) step();
      @(negedge clk) rst = 1'b1;
      step();
      chk("R12", q, 1'b0);
      chk("R1", q_n, 1'b1);
      @(negedge clk) a = 1'b1;
      @(negedge clk) a = 1'b0;          // falls while reset is held
      @(negedge clk) rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R12", q, 1'b0);
      end

      $display("%0d/%0d checks passed", total - failed, total);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end
endmodule